// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block sits between a simple host-side request port and the pins of a raw NAND flash device on an asynchronous static-memory bus. The host presents one request at a time. A request is a command byte, an address byte, a data write or a data read. The sequencer turns each request into a complete strobe sequence on the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins, and it drives the data bus while it owns it.

Every access moves through four timed phases: setup, strobe, hold and bus release. The length of each phase comes from a byte-wide field of a timing word. A control word supplies the enable, the wait-on-busy switch, the bus width and two gaps that separate a read from a preceding command or address. When a read completes, its data is returned as a single-cycle response. A multi-byte address is sent as a series of separate address requests, and each one produces its own full sequence.

The request port follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the host must hold its fields stable until that edge. `req_ready` is high only when the sequencer is idle, enabled and not stalled by a busy device. The response port has no back-pressure: `rsp_valid` is high for exactly one cycle. The control and timing words must stay unchanged while an access is in progress.

Top module: `nand_bus_sequencer`

## Requirements
- R1: After reset `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale` and `bus_oe` are low, and `req_ready` is high when control bit 2 (enable) is set.
- R2: `req_kind` encodes 0 = command, 1 = address, 2 = data write and 3 = data read. `nand_cle` is high only during the setup, strobe and hold of a command, and `nand_ale` only during those phases of an address.
- R3: Timing word bits [7:0] set the setup length and bits [15:8] set the strobe length. A field value N gives N+1 cycles. During the strobe phase `nand_we_n` is low for kinds 0–2 and `nand_re_n` is low for kind 3.
- R4: Timing word bits [23:16] give the hold length in cycles, and a value of 0 counts as 1. Bits [31:24] give the release length in cycles, and 0 skips the phase. During release `nand_ce_n` is high and no request is accepted.
- R5: `bus_oe` is high from the first setup cycle through the last hold cycle of kinds 0–2 and never high for reads. `bus_dout` is zero whenever `bus_oe` is low. Command and address bytes leave the upper byte zero.
- R6: With control bit 4 (wide) set, data writes drive all 16 bits and data reads return all 16 bits. With bit 4 clear, the upper byte is zero in both directions.
- R7: Read data is sampled from `bus_din` on the last strobe cycle. `rsp_valid` is high for exactly one cycle, the first hold cycle, with that data on `rsp_data`.
- R8: A read that directly follows a command is preceded by control bits [12:9] cycles with `nand_ce_n` low and every other strobe inactive. A read that follows an address gets bits [16:13] cycles in the same way. A read after a data access gets no gap.
- R9: With control bit 1 (wait-on-busy) set and `nand_rb` low, `req_ready` stays low, no access starts and all strobes stay inactive.
- R10: Clearing control bit 2 lets an access in progress run to completion. From then on `req_ready` stays low and every strobe stays inactive.
- R11: Address requests issued back to back each produce a complete setup, strobe, hold and release sequence of their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Control word: wait-on-busy [1], enable [2], wide [4], command-to-read gap [12:9], address-to-read gap [16:13] |
| timing_word | input | 4*CNT_W | Phase lengths: setup, strobe, hold, release |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_kind | input | 2 | Request kind (command, address, write, read) |
| req_wdata | input | DW | Command, address or write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | DW | Read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb | input | 1 | Device ready (high) / busy (low) |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | DW | Data bus output value |
| bus_din | input | DW | Data bus input value |

## Verification
The bench uses the default parameters: a 16-bit bus, 8-bit phase counters and 4-bit gap fields. It programs only small field values, so every phase boundary falls within a few cycles. With these settings it reaches all-zero timing (one-cycle setup and strobe, a hold forced to one cycle, release skipped), a long mixed setting, the 16-bit lane in both directions, the two read gaps with distinct lengths, a busy stall and a disable taken mid-access. A behavioural model expands each accepted request into its expected per-cycle pin values and compares them, together with the ready line, on every cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WDATA = 2'd2,
    KIND_RDATA = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_HIZ
  } phase_e;

  // control word bit positions
  localparam int CTL_WAITON_BIT = 1;
  localparam int CTL_EN_BIT     = 2;
  localparam int CTL_WIDE_BIT   = 4;
  localparam int CTL_CLR_LSB    = 9;
  localparam int CTL_AR_LSB     = 13;

endpackage

// File: rtl/nand_phase_ctr.sv
module nand_phase_ctr
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  acc_kind_e        start_kind,
  input  logic [CNT_W-1:0] t_setup,
  input  logic [CNT_W-1:0] t_strobe,
  input  logic [CNT_W-1:0] t_hold,
  input  logic [CNT_W-1:0] t_hiz,
  input  logic [GAP_W-1:0] gap_clr,
  input  logic [GAP_W-1:0] gap_ar,
  output phase_e           phase,
  output acc_kind_e        kind,
  output logic             last_strobe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hold_len;
  logic [GAP_W-1:0] gap_len;
  acc_kind_e        prev_kind;

  // read-after-command / read-after-address turnaround
  always_comb begin
    gap_len = '0;
    if (start_kind == KIND_RDATA) begin
      if (prev_kind == KIND_CMD)       gap_len = gap_clr;
      else if (prev_kind == KIND_ADDR) gap_len = gap_ar;
    end
  end

  assign hold_len    = (t_hold == '0) ? ONE : t_hold;
  assign last_strobe = (phase == PH_STROBE) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      kind      <= KIND_WDATA;
      prev_kind <= KIND_WDATA;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          kind      <= start_kind;
          prev_kind <= start_kind;
          if (gap_len != '0) begin
            phase <= PH_GAP;
            cnt   <= CNT_W'(gap_len) - ONE;
          end else begin
            phase <= PH_SETUP;
            cnt   <= t_setup;
          end
        end
        PH_GAP: if (cnt == '0) begin
          phase <= PH_SETUP;
          cnt   <= t_setup;
        end else cnt <= cnt - ONE;
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= t_strobe;
        end else cnt <= cnt - ONE;
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= hold_len - ONE;
        end else cnt <= cnt - ONE;
        PH_HOLD: if (cnt == '0) begin
          if (t_hiz != '0) begin
            phase <= PH_HIZ;
            cnt   <= t_hiz - ONE;
          end else phase <= PH_IDLE;
        end else cnt <= cnt - ONE;
        PH_HIZ: if (cnt == '0) phase <= PH_IDLE;
                else cnt <= cnt - ONE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: the strobe phase is only ever entered from setup
  a_r3_strobe_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE && $past(phase) != PH_STROBE) |-> ($past(phase) == PH_SETUP));

  // R4: release leads only to idle
  a_r4_hiz_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIZ) |=> (phase == PH_HIZ || phase == PH_IDLE));

  // R8: a gap is always followed by setup
  a_r8_gap_to_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP) |=> (phase == PH_GAP || phase == PH_SETUP));

endmodule

// File: rtl/nand_bus_drive.sv
module nand_bus_drive
  import nand_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  acc_kind_e     start_kind,
  input  logic [DW-1:0] start_data,
  input  logic          wide,
  input  phase_e        phase,
  input  acc_kind_e     kind,
  input  logic          last_strobe,
  input  logic [DW-1:0] din,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic          oe,
  output logic [DW-1:0] dout,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  localparam logic [DW-1:0] LOW_MASK = DW'(8'hFF);

  logic [DW-1:0] data_q;
  logic          wide_q;
  logic          active;
  logic          is_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      wide_q <= 1'b0;
    end else if (start) begin
      wide_q <= wide;
      data_q <= (wide && start_kind == KIND_WDATA) ? start_data
                                                   : (start_data & LOW_MASK);
    end
  end

  assign active  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign is_read = (kind == KIND_RDATA);

  assign ce_n = !(active || phase == PH_GAP);
  assign cle  = active && (kind == KIND_CMD);
  assign ale  = active && (kind == KIND_ADDR);
  assign we_n = !((phase == PH_STROBE) && !is_read);
  assign re_n = !((phase == PH_STROBE) && is_read);
  assign oe   = active && !is_read;
  assign dout = oe ? data_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= last_strobe && is_read;
      if (last_strobe && is_read)
        rsp_data <= wide_q ? din : (din & LOW_MASK);
    end
  end

  // R2: command and address latches never together
  a_r2_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R3: never both strobes low
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R5: the data bus is driven only while the device is selected
  a_r5_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !ce_n);

  // R7: read response is a single-cycle pulse
  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/nand_bus_sequencer.sv
module nand_bus_sequencer
  import nand_seq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 8,
  parameter int GAP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        ctrl_word,
  input  logic [4*CNT_W-1:0] timing_word,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_data,
  output logic               nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  input  logic               nand_rb,
  output logic               bus_oe,
  output logic [DW-1:0]      bus_dout,
  input  logic [DW-1:0]      bus_din
);

  logic      en;
  logic      waiton;
  logic      wide;
  logic      start;
  logic      last_strobe;
  phase_e    phase;
  acc_kind_e kind;
  acc_kind_e in_kind;
  logic      unused_ctrl;

  assign en      = ctrl_word[CTL_EN_BIT];
  assign waiton  = ctrl_word[CTL_WAITON_BIT];
  assign wide    = ctrl_word[CTL_WIDE_BIT];
  assign in_kind = acc_kind_e'(req_kind);
  assign unused_ctrl = ^{ctrl_word[31:CTL_AR_LSB+GAP_W], ctrl_word[8:5],
                         ctrl_word[3], ctrl_word[0]};

  assign req_ready = (phase == PH_IDLE) && en && !(waiton && !nand_rb);
  assign start     = req_valid && req_ready;

  nand_phase_ctr #(.CNT_W(CNT_W), .GAP_W(GAP_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (in_kind),
    .t_setup    (timing_word[0*CNT_W +: CNT_W]),
    .t_strobe   (timing_word[1*CNT_W +: CNT_W]),
    .t_hold     (timing_word[2*CNT_W +: CNT_W]),
    .t_hiz      (timing_word[3*CNT_W +: CNT_W]),
    .gap_clr    (ctrl_word[CTL_CLR_LSB +: GAP_W]),
    .gap_ar     (ctrl_word[CTL_AR_LSB +: GAP_W]),
    .phase      (phase),
    .kind       (kind),
    .last_strobe(last_strobe)
  );

  nand_bus_drive #(.DW(DW)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (in_kind),
    .start_data (req_wdata),
    .wide       (wide),
    .phase      (phase),
    .kind       (kind),
    .last_strobe(last_strobe),
    .din        (bus_din),
    .ce_n       (nand_ce_n),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .oe         (bus_oe),
    .dout       (bus_dout),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  // R9: a busy device keeps the sequencer parked
  a_r9_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (waiton && !nand_rb && phase == PH_IDLE) |=> (phase == PH_IDLE));

  // R10: once disabled and idle, nothing starts
  a_r10_off_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && phase == PH_IDLE) |=> (phase == PH_IDLE && nand_ce_n));

endmodule

// File: tb/nand_bus_sequencer_bench.sv
module nand_bus_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   ctrl_word = 32'h4;
  logic [31:0]   timing_word = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic          nand_rb = 1'b1;
  logic          bus_oe;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";
  logic [38:0] exp_q[$];
  int m_prev = 2;
  logic [DW-1:0] last_rsp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_sequencer u_nand_bus_sequencer (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .timing_word(timing_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb(nand_rb),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  function automatic logic [38:0] pack(logic ce_n, logic cle, logic ale, logic we_n,
                                       logic re_n, logic oe, logic rv,
                                       logic [15:0] d, logic [15:0] r);
    return {ce_n, cle, ale, we_n, re_n, oe, rv, d, r};
  endfunction

  localparam logic [38:0] IDLE_V = {7'b1001100, 16'h0, 16'h0};

  task automatic check(string req, logic ok, logic [38:0] act, logic [38:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // model: expand one accepted request into expected per-cycle pin values
  task automatic push_access(logic [1:0] k, logic [15:0] wd, logic [15:0] din);
    int gap, tsu, tst, tho, thz;
    logic wide, wr, cl, al;
    logic [15:0] dv, rv;
    wide = ctrl_word[4];
    tsu = int'(timing_word[7:0]);
    tst = int'(timing_word[15:8]);
    tho = int'(timing_word[23:16]);
    if (tho == 0) tho = 1;
    thz = int'(timing_word[31:24]);
    gap = 0;
    if (k == 2'd3) begin
      if (m_prev == 0) gap = int'(ctrl_word[12:9]);
      else if (m_prev == 1) gap = int'(ctrl_word[16:13]);
    end
    m_prev = int'(k);
    wr = (k != 2'd3);
    cl = (k == 2'd0);
    al = (k == 2'd1);
    dv = !wr ? 16'h0 : ((k == 2'd2 && wide) ? wd : {8'h00, wd[7:0]});
    rv = wide ? din : {8'h00, din[7:0]};
    for (int i = 0; i < gap; i++) exp_q.push_back(pack(0, 0, 0, 1, 1, 0, 0, 16'h0, 16'h0));
    for (int i = 0; i <= tsu; i++) exp_q.push_back(pack(0, cl, al, 1, 1, wr, 0, dv, 16'h0));
    for (int i = 0; i <= tst; i++) exp_q.push_back(pack(0, cl, al, !wr, wr, wr, 0, dv, 16'h0));
    for (int i = 0; i < tho; i++)
      exp_q.push_back(pack(0, cl, al, 1, 1, wr, (i == 0) && !wr, dv,
                           ((i == 0) && !wr) ? rv : 16'h0));
    for (int i = 0; i < thz; i++) exp_q.push_back(IDLE_V);
  endtask

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic ready_exp;
      logic [38:0] exp_v, act_v;
      ready_exp = (exp_q.size() == 0) && ctrl_word[2] && !(ctrl_word[1] && !nand_rb);
      check({tag, " ready"}, req_ready == ready_exp, {38'h0, req_ready}, {38'h0, ready_exp});
      exp_v = (exp_q.size() != 0) ? exp_q[0] : IDLE_V;
      act_v = pack(nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, bus_oe, rsp_valid,
                   bus_dout, rsp_valid ? rsp_data : 16'h0);
      check({tag, " pins"}, act_v == exp_v, act_v, exp_v);
      if (rsp_valid) last_rsp = rsp_data;
      if (exp_q.size() != 0) void'(exp_q.pop_front());
      if (req_valid && ready_exp) push_access(req_kind, req_wdata, bus_din);
    end
  end

  task automatic send(logic [1:0] k, logic [15:0] d);
    req_kind = k;
    req_wdata = d;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0);
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL %s watchdog: actual hung expected finished", tag);
      summary();
      $finish;
    end
  end

  initial begin
    ctrl_word = 32'h4;
    timing_word = {8'd2, 8'd1, 8'd2, 8'd1};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle pins and ready after reset
    check("R1", nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale &&
          !bus_oe && req_ready, {32'h0, nand_ce_n, nand_we_n, nand_re_n, nand_cle,
          nand_ale, bus_oe, req_ready}, {32'h0, 7'b1110001});
    @(posedge clk); #1;

    tag = "R2";  send(2'd0, 16'h0070); send(2'd1, 16'h0012); drain();
    tag = "R11"; send(2'd1, 16'h0001); send(2'd1, 16'h0002); send(2'd1, 16'h0003); drain();
    tag = "R5";  send(2'd2, 16'hA5C3); drain();

    tag = "R8";
    ctrl_word = 32'h4 | (32'd3 << 9) | (32'd2 << 13);
    bus_din = 16'h5A3C;
    send(2'd0, 16'h0090); send(2'd3, 16'h0); drain();
    check("R7", last_rsp == 16'h003C, {23'h0, last_rsp}, {23'h0, 16'h003C});
    send(2'd1, 16'h0044); send(2'd3, 16'h0); send(2'd3, 16'h0); drain();

    tag = "R3";
    timing_word = 32'h0;
    send(2'd0, 16'h00FF); send(2'd3, 16'h0); send(2'd2, 16'h0011); drain();
    tag = "R4";
    timing_word = {8'd0, 8'd3, 8'd5, 8'd4};
    send(2'd2, 16'h0022); send(2'd1, 16'h0033); send(2'd3, 16'h0); drain();

    tag = "R6";
    ctrl_word = 32'h14;
    timing_word = {8'd1, 8'd1, 8'd1, 8'd0};
    bus_din = 16'h1234;
    send(2'd2, 16'hBEEF); send(2'd3, 16'h0); drain();
    check("R6", last_rsp == 16'h1234, {23'h0, last_rsp}, {23'h0, 16'h1234});
    send(2'd0, 16'hABCD); drain();

    tag = "R9";
    ctrl_word = 32'h6;
    nand_rb = 1'b0;
    req_kind = 2'd0; req_wdata = 16'h0060; req_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R9", !req_ready && nand_ce_n, {37'h0, req_ready, nand_ce_n}, {37'h0, 2'b01});
    end
    @(posedge clk); #1 nand_rb = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 1'b0;
    drain();

    tag = "R10";
    ctrl_word = 32'h4;
    send(2'd2, 16'h0077);
    ctrl_word = 32'h0;
    drain();
    req_kind = 2'd0; req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R10", !req_ready && nand_ce_n && nand_we_n,
            {36'h0, req_ready, nand_ce_n, nand_we_n}, {36'h0, 3'b011});
    end
    @(posedge clk); #1 req_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    done = 1;
    summary();
    $finish;
  end

endmodule